// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block is the coherence engine attached to one core's private data cache on a shared snooping bus. It holds a small direct-mapped array of one-word lines. Each line carries a tag, a data word and one of four coherence states: Modified (sole, dirty), Exclusive (sole, clean), Shared (read-only, perhaps held elsewhere) and Invalid. The processor side sends read and write requests and waits for an acknowledge. When the line state is not enough to finish a request, the controller raises a bus request and waits for the grant and for completion. It then updates the line and replays the request as a hit on the next cycle.

On the snoop side the controller watches transactions that other cores place on the bus. It answers in the same cycle by asserting a shared response, by flushing a dirty word, or both. At the next clock edge it downgrades or invalidates its own copy. Together with the other controllers on the bus, this keeps a single writer or several readers for every line, never both at once. The design assumes that the snoop input never carries a transaction while this controller holds the bus grant.

Address split: the low `IDX_W` bits select the line and the remaining upper bits form the tag. Command coding is the same on the bus and snoop sides: 0 = write-back, 1 = read, 2 = read-for-ownership, 3 = upgrade/invalidate. State coding is I=0, S=1, E=2, M=3.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_ack`, `snoop_shared` and `snoop_flush` are low.
- R2: A read to a line not held (tag mismatch or Invalid) raises `bus_req` with command 1 and the request address. In the cycle where `bus_gnt` and `bus_done` are both high, the line is filled from `bus_rdata`: it becomes Exclusive if `bus_shared_in` is low and Shared if it is high. `cpu_ack` rises one cycle later with the filled word on `cpu_rdata`.
- R3: A read to any valid held line, or a write to a held line in E or M, raises `cpu_ack` in the same cycle as `cpu_req`, with `bus_req` low. Such a write stores `cpu_wdata` and leaves the line Modified.
- R4: A write to a held line in S raises `bus_req` with command 3. On completion the line becomes Modified, and the write is acknowledged and stored in the following cycle.
- R5: A write to a line not held raises `bus_req` with command 2. On completion the line is filled from `bus_rdata` as Modified, and the write is acknowledged and stored in the following cycle.
- R6: On a miss whose slot holds a Modified line with another tag, the controller first issues command 0 with the victim's address on `bus_addr` and its word on `bus_wdata`, and only then the miss command. A victim in E or S is replaced with no bus transaction.
- R7: A snooped command 1 that hits a held line asserts `snoop_shared` in that cycle. The line becomes Shared. If the line was Modified, `snoop_flush` is high and `snoop_data` carries its word.
- R8: A snooped command 2 or 3 that hits a held line invalidates it and leaves `snoop_shared` low. Only command 2 on a Modified line flushes its word.
- R9: A snooped command 0, or a snoop whose address is not held, drives no response and changes no line.
- R10: If a pending upgrade's line is invalidated by a snoop before the grant, the pending command becomes 2.
- R11: If a pending victim write-back's line leaves M through a snoop before the grant, the write-back is dropped: `bus_req` falls and the miss command follows.
- R12: A processor request whose line index equals the index of an active snoop is not served in that cycle.
- R13: While `bus_req` and `bus_gnt` are high and `bus_done` is low, `bus_req`, `bus_cmd` and `bus_addr` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_done | input | 1 | Granted transaction completes this cycle |
| bus_cmd | output | 2 | Outgoing command |
| bus_addr | output | ADDR_W | Outgoing address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data at completion |
| bus_shared_in | input | 1 | Another cache holds the line, at completion |
| snoop_valid | input | 1 | Another core's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_flush | output | 1 | This cache supplies dirty data |
| snoop_data | output | DATA_W | Flushed word |

## Verification
The bound checker watches several rules on every cycle. A hit acknowledge never coincides with a bus request. A flush only answers a real snoop, and a flush on a read also signals sharing. A write-back snoop never draws a response. A request on a snooped index is held off, a granted transaction keeps its command and address, and a snooped invalidation leaves the line gone one cycle later. The state sequences can only be shown by the bench's scenarios, which a behavioural model follows cycle by cycle. These cover the E-versus-S fill choice, the silent E-to-M write, the ordering of a dirty victim write-back before a miss, the upgrade that turns into read-for-ownership, and the write-back dropped after a snooped read.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_done,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              snoop_flush,
  output logic [DATA_W-1:0] snoop_data
);
  localparam int NL    = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] C_WB = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_UPG = 2'd3;
  localparam logic [1:0] P_IDLE = 2'd0, P_WB = 2'd1, P_XACT = 2'd2;

  logic [NL-1:0][1:0]        st;
  logic [NL-1:0][TAG_W-1:0]  tg;
  logic [NL-1:0][DATA_W-1:0] dat;
  logic [1:0] phase, pcmd;

  logic [IDX_W-1:0] cidx, sidx;
  logic [TAG_W-1:0] ctag, stag;
  logic [1:0] cst, sst;
  logic chit, shit, sblock, xfer;

  assign cidx = cpu_addr[IDX_W-1:0];
  assign ctag = cpu_addr[ADDR_W-1:IDX_W];
  assign sidx = snoop_addr[IDX_W-1:0];
  assign stag = snoop_addr[ADDR_W-1:IDX_W];
  assign cst  = st[cidx];
  assign sst  = st[sidx];

  assign chit   = (cst != ST_I) && (tg[cidx] == ctag);
  assign shit   = snoop_valid && (snoop_cmd != C_WB) && (sst != ST_I) && (tg[sidx] == stag);
  assign sblock = snoop_valid && (sidx == cidx);

  assign cpu_ack   = (phase == P_IDLE) && cpu_req && !sblock && chit && (!cpu_we || cst[1]);
  assign cpu_rdata = dat[cidx];

  assign bus_req   = (phase == P_XACT) || ((phase == P_WB) && (cst == ST_M));
  assign bus_cmd   = (phase == P_WB) ? C_WB : pcmd;
  assign bus_addr  = (phase == P_WB) ? {tg[cidx], cidx} : cpu_addr;
  assign bus_wdata = dat[cidx];
  assign xfer      = bus_req && bus_gnt && bus_done;

  assign snoop_shared = shit && (snoop_cmd == C_RD);
  assign snoop_flush  = shit && (sst == ST_M) && (snoop_cmd != C_UPG);
  assign snoop_data   = dat[sidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= '0;
      tg    <= '0;
      dat   <= '0;
      phase <= P_IDLE;
      pcmd  <= C_RD;
    end else begin
      case (phase)
        P_IDLE: begin
          if (cpu_req && !sblock) begin
            if (cpu_ack) begin
              if (cpu_we) begin
                dat[cidx] <= cpu_wdata;
                st[cidx]  <= ST_M;
              end
            end else if (chit) begin
              pcmd  <= C_UPG;
              phase <= P_XACT;
            end else begin
              pcmd  <= cpu_we ? C_RDX : C_RD;
              phase <= (cst == ST_M) ? P_WB : P_XACT;
            end
          end
        end
        P_WB: begin
          if (cst != ST_M) begin
            phase <= P_XACT;
          end else if (xfer) begin
            st[cidx] <= ST_I;
            phase    <= P_XACT;
          end
        end
        P_XACT: begin
          if (xfer) begin
            phase <= P_IDLE;
            case (pcmd)
              C_UPG: st[cidx] <= ST_M;
              C_RDX: begin
                tg[cidx]  <= ctag;
                dat[cidx] <= bus_rdata;
                st[cidx]  <= ST_M;
              end
              default: begin
                tg[cidx]  <= ctag;
                dat[cidx] <= bus_rdata;
                st[cidx]  <= bus_shared_in ? ST_S : ST_E;
              end
            endcase
          end else if ((pcmd == C_UPG) && shit && (sidx == cidx) && snoop_cmd[1]) begin
            pcmd <= C_RDX;
          end
        end
        default: phase <= P_IDLE;
      endcase
      if (shit) st[sidx] <= (snoop_cmd == C_RD) ? ST_S : ST_I;
    end
  end
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   cpu_ack,
  input logic [ADDR_W-1:0]                      cpu_addr,
  input logic                                   bus_req,
  input logic                                   bus_gnt,
  input logic                                   bus_done,
  input logic [1:0]                             bus_cmd,
  input logic [ADDR_W-1:0]                      bus_addr,
  input logic                                   snoop_valid,
  input logic [1:0]                             snoop_cmd,
  input logic [ADDR_W-1:0]                      snoop_addr,
  input logic                                   snoop_shared,
  input logic                                   snoop_flush,
  input logic [(1<<IDX_W)-1:0][1:0]             st,
  input logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0] tg
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             inv_q;
  logic [IDX_W-1:0] sidx_q;
  logic [TAG_W-1:0] stag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_q  <= 1'b0;
      sidx_q <= '0;
      stag_q <= '0;
    end else begin
      inv_q  <= snoop_valid && snoop_cmd[1];
      sidx_q <= snoop_addr[IDX_W-1:0];
      stag_q <= snoop_addr[ADDR_W-1:IDX_W];
    end
  end

  assert_hit_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !bus_req);

  assert_flush_needs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_flush |-> snoop_valid && snoop_cmd != 2'd0);

  assert_flush_on_read_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_flush && snoop_cmd == 2'd1) |-> snoop_shared);

  assert_invalidate_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_q |-> !(st[sidx_q] != 2'd0 && tg[sidx_q] == stag_q));

  assert_writeback_snoop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == 2'd0) |-> !snoop_shared && !snoop_flush);

  assert_snoop_blocks_cpu_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) |-> !cpu_ack);

  assert_grant_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_done) |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_addr(cpu_addr),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_done(bus_done),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
  .snoop_shared(snoop_shared), .snoop_flush(snoop_flush),
  .st(st), .tg(tg)
);

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;
  localparam int AW = 8, DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cpu_req, cpu_we, cpu_ack, bus_req, bus_gnt, bus_done, bus_shared_in;
  logic snoop_valid, snoop_shared, snoop_flush;
  logic [AW-1:0] cpu_addr, bus_addr, snoop_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, bus_wdata, bus_rdata, snoop_data;
  logic [1:0] bus_cmd, snoop_cmd;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_shared_in(bus_shared_in), .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd),
    .snoop_addr(snoop_addr), .snoop_shared(snoop_shared), .snoop_flush(snoop_flush),
    .snoop_data(snoop_data));

  int total = 0, bad = 0;
  int m_st[4], m_tg[4], m_dat[4];
  int m_ph, m_pc;
  bit last_ack;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_breq();
    int ci = int'(cpu_addr) % 4;
    return (m_ph == 2) || (m_ph == 1 && m_st[ci] == 3);
  endfunction

  task automatic step(string tag);
    int ci, ct, si, stg, cst, ecmd, eaddr;
    bit chit, shit, sblk, ack, breq, flush, xfer;
    #1;
    ci = int'(cpu_addr) % 4;  ct = int'(cpu_addr) / 4;
    si = int'(snoop_addr) % 4; stg = int'(snoop_addr) / 4;
    cst  = m_st[ci];
    chit = cst != 0 && m_tg[ci] == ct;
    shit = snoop_valid && snoop_cmd != 0 && m_st[si] != 0 && m_tg[si] == stg;
    sblk = snoop_valid && si == ci;
    ack  = m_ph == 0 && cpu_req && !sblk && chit && (!cpu_we || cst >= 2);
    breq = exp_breq();
    flush = shit && m_st[si] == 3 && snoop_cmd != 3;
    chk(tag, "cpu_ack", 32'(cpu_ack), 32'(ack));
    if (ack) chk(tag, "cpu_rdata", 32'(cpu_rdata), m_dat[ci]);
    chk(tag, "bus_req", 32'(bus_req), 32'(breq));
    if (breq) begin
      ecmd  = (m_ph == 1) ? 0 : m_pc;
      eaddr = (m_ph == 1) ? m_tg[ci] * 4 + ci : int'(cpu_addr);
      chk(tag, "bus_cmd", 32'(bus_cmd), ecmd);
      chk(tag, "bus_addr", 32'(bus_addr), eaddr);
      if (m_ph == 1) chk(tag, "bus_wdata", 32'(bus_wdata), m_dat[ci]);
    end
    chk(tag, "snoop_shared", 32'(snoop_shared), 32'(shit && snoop_cmd == 1));
    chk(tag, "snoop_flush", 32'(snoop_flush), 32'(flush));
    if (flush) chk(tag, "snoop_data", 32'(snoop_data), m_dat[si]);
    last_ack = ack;
    xfer = breq && bus_gnt && bus_done;
    case (m_ph)
      0: if (cpu_req && !sblk) begin
        if (ack) begin
          if (cpu_we) begin m_dat[ci] = int'(cpu_wdata); m_st[ci] = 3; end
        end else if (chit) begin m_pc = 3; m_ph = 2; end
        else begin m_pc = cpu_we ? 2 : 1; m_ph = (cst == 3) ? 1 : 2; end
      end
      1: if (cst != 3) m_ph = 2;
         else if (xfer) begin m_st[ci] = 0; m_ph = 2; end
      default: if (xfer) begin
        m_ph = 0;
        if (m_pc == 3) m_st[ci] = 3;
        else begin
          m_tg[ci] = ct; m_dat[ci] = int'(bus_rdata);
          m_st[ci] = (m_pc == 2) ? 3 : (bus_shared_in ? 1 : 2);
        end
      end else if (m_pc == 3 && shit && si == ci && snoop_cmd >= 2) m_pc = 2;
    endcase
    if (shit) m_st[si] = (snoop_cmd == 1) ? 1 : 0;
    @(negedge clk);
  endtask

  task automatic op(bit we, int a, int wd, int dly, int rd, bit sh, string tag);
    int w = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    for (int n = 0; n < 40; n++) begin
      bus_gnt = 0; bus_done = 0;
      if (exp_breq()) begin
        if (w >= dly) begin
          bus_gnt = 1; bus_done = 1; bus_rdata = DW'(rd); bus_shared_in = sh; w = 0;
        end else w++;
      end
      step(tag);
      if (last_ack) break;
    end
    cpu_req = 0; bus_gnt = 0; bus_done = 0;
    step(tag);
  endtask

  task automatic snp(int cmd, int a, string tag);
    snoop_valid = 1; snoop_cmd = 2'(cmd); snoop_addr = AW'(a);
    step(tag);
    snoop_valid = 0; snoop_cmd = 0;
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dat[i] = 0; end
    m_ph = 0; m_pc = 1;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; bus_done = 0; bus_rdata = 0; bus_shared_in = 0;
    snoop_valid = 0; snoop_cmd = 0; snoop_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1", "bus_req in reset", 32'(bus_req), 0);
    rst_n = 1;
    step("R1");

    op(0, 'h05, 0, 2, 'h1111, 0, "R2");
    op(1, 'h05, 'h2222, 0, 0, 0, "R3");
    op(0, 'h05, 0, 0, 0, 0, "R3");
    snp(1, 'h05, "R7");
    op(0, 'h05, 0, 0, 0, 0, "R3");
    op(1, 'h05, 'h3333, 1, 0, 0, "R4");
    snp(2, 'h05, "R8");
    op(0, 'h05, 0, 1, 'h3333, 1, "R2");
    snp(3, 'h05, "R8");
    op(1, 'h09, 'h5555, 0, 'h4444, 0, "R5");
    op(0, 'h0D, 0, 1, 'h6666, 0, "R6");
    op(0, 'h01, 0, 0, 'h1234, 1, "R6");
    snp(1, 'h01, "R7");
    snp(0, 'h01, "R9");
    snp(2, 'h11, "R9");
    op(0, 'h01, 0, 0, 0, 0, "R9");
    op(0, 'h06, 0, 0, 'h0a0a, 0, "R2");
    snp(1, 'h06, "R7");
    op(1, 'h06, 'hbeef, 0, 0, 0, "R7");

    op(0, 'h02, 0, 0, 'h2020, 1, "R10");
    cpu_req = 1; cpu_we = 1; cpu_addr = 'h02; cpu_wdata = 'h9999;
    step("R10"); step("R10");
    snoop_valid = 1; snoop_cmd = 2; snoop_addr = 'h02;
    step("R10");
    snoop_valid = 0; snoop_cmd = 0;
    step("R10");
    bus_gnt = 1; bus_done = 0;
    step("R13");
    bus_done = 1; bus_rdata = 'h7777;
    step("R10");
    bus_gnt = 0; bus_done = 0;
    step("R10");
    cpu_req = 0;
    step("R10");
    op(0, 'h02, 0, 0, 0, 0, "R10");

    op(1, 'h03, 'h3030, 0, 0, 0, "R11");
    cpu_req = 1; cpu_we = 0; cpu_addr = 'h07;
    step("R11"); step("R11");
    snoop_valid = 1; snoop_cmd = 1; snoop_addr = 'h03;
    step("R11");
    snoop_valid = 0; snoop_cmd = 0;
    step("R11"); step("R11");
    bus_gnt = 1; bus_done = 1; bus_rdata = 'h7070; bus_shared_in = 0;
    step("R11");
    bus_gnt = 0; bus_done = 0;
    step("R11");
    cpu_req = 0;
    step("R11");

    cpu_req = 1; cpu_we = 0; cpu_addr = 'h01;
    snoop_valid = 1; snoop_cmd = 1; snoop_addr = 'h05;
    step("R12");
    snoop_valid = 0; snoop_cmd = 0;
    step("R12");
    cpu_req = 0;
    step("R12");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule